// File: doc/BRIEF.md
# Banked File-Register Address Unit

This block turns each file-register access of a small accumulator core into a 9-bit data-memory address. Data memory is split into four banks of 128 bytes each. A direct access takes the 7-bit register field of the instruction as the offset inside a bank. It takes the bank number from two direct-bank bits held in a bank-control register.

When the field names the window offset, the access becomes indirect. The address is then formed from an 8-bit pointer register and one indirect-bank bit, which supplies the ninth address bit. A read through the window returns the byte the pointer selects; the window stores nothing of its own. The pointer can be advanced by one with a strobe, so a loop can sweep a run of consecutive bytes.

Three offsets appear at the same place in every bank: the window, the pointer and the bank-control register. These offsets are served by the unit itself. Every other offset reaches a four-bank RAM model inside the block. Read data appears one cycle after the access.

Top module: `banked_addr_unit`

## Requirements
- R1: After reset the pointer and the bank-control register read as 0x00 and `rd_valid` is low.
- R2: A direct access (field not 0x00) drives `mem_addr` = {bank-control bits [1:0], field} in the same cycle.
- R3: An access with field 0x00 (the window) drives `mem_addr` = {bank-control bit 2, pointer} in the same cycle.
- R4: A read raises `rd_valid` one cycle later, with `rd_data` equal to the byte last written at `mem_addr`.
- R5: Reading the window returns the contents of the location the pointer addresses.
- R6: The pointer (offset 0x04) and the bank-control register (offset 0x03) are reached from every bank.
- R7: `ptr_inc` adds one to the pointer, wrapping from 0xFF to 0x00. A write to the pointer in the same cycle takes priority over the increment.
- R8: A window access whose pointer has low seven bits 0x00 reads 0x00, and its write is discarded.
- R9: The bank-control register keeps only bits [2:0]. Bits [7:3] always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_field | input | 7 | Register field of the instruction |
| acc_wdata | input | 8 | Write data |
| ptr_inc | input | 1 | Advance the pointer by one |
| mem_addr | output | 9 | Resolved data-memory address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
The same offset 0x20 is written in two different banks, and both copies are read back. This shows whether the direct-bank bits really select the bank, or whether banks alias. Window reads with the indirect-bank bit at each value separate the indirect bank bit from the direct ones. A clearing sweep writes through the window while incrementing the pointer. It shows whether the write uses the pointer from before or after the increment. Pointer values 0xFF, 0x80 and a write with increment in the same cycle cover the wrap, the self-reference and the write priority.

// File: rtl/bau_pkg.sv
package bau_pkg;
  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_PTR  = 2'd1,
    TGT_BCTL = 2'd2,
    TGT_NULL = 2'd3
  } bau_tgt_e;
endpackage

// File: rtl/bau_decode.sv
module bau_decode
  import bau_pkg::*;
#(
  parameter int unsigned OFS_W    = 7,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned WIN_OFS  = 0,
  parameter int unsigned PTR_OFS  = 4,
  parameter int unsigned BCTL_OFS = 3,
  localparam int unsigned AW      = OFS_W + BANK_W,
  localparam int unsigned PTR_W   = OFS_W + 1,
  localparam int unsigned IBANK_W = AW - PTR_W
) (
  input  logic [OFS_W-1:0]   field,
  input  logic [BANK_W-1:0]  dbank,
  input  logic [IBANK_W-1:0] ibank,
  input  logic [PTR_W-1:0]   ptr,
  output logic [AW-1:0]      addr,
  output bau_tgt_e           tgt,
  output logic               is_win,
  output logic               self_ref
);
  function automatic logic [AW-1:0] dir_addr(input logic [BANK_W-1:0] b,
                                             input logic [OFS_W-1:0] f);
    return {b, f};
  endfunction

  function automatic logic [AW-1:0] ind_addr(input logic [IBANK_W-1:0] ib,
                                             input logic [PTR_W-1:0] p);
    return {ib, p};
  endfunction

  logic [OFS_W-1:0] low;

  always_comb begin
    is_win = (field == OFS_W'(WIN_OFS));
    addr   = is_win ? ind_addr(ibank, ptr) : dir_addr(dbank, field);
    low    = addr[OFS_W-1:0];
    if (low == OFS_W'(WIN_OFS))       tgt = TGT_NULL;
    else if (low == OFS_W'(PTR_OFS))  tgt = TGT_PTR;
    else if (low == OFS_W'(BCTL_OFS)) tgt = TGT_BCTL;
    else                              tgt = TGT_RAM;
    self_ref = is_win && (tgt == TGT_NULL);
  end
endmodule

// File: rtl/bau_ctrl_regs.sv
module bau_ctrl_regs #(
  parameter int unsigned DW      = 8,
  parameter int unsigned PTR_W   = 8,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned IBANK_W = 1,
  localparam int unsigned CTL_W  = BANK_W + IBANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ptr,
  input  logic               wr_bctl,
  input  logic               inc,
  input  logic [DW-1:0]      wdata,
  output logic [PTR_W-1:0]   ptr_q,
  output logic [BANK_W-1:0]  dbank,
  output logic [IBANK_W-1:0] ibank,
  output logic [DW-1:0]      bctl_byte
);
  logic [CTL_W-1:0] ctl_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (wr_ptr) begin
      ptr_q <= wdata[PTR_W-1:0];
    end else if (inc) begin
      ptr_q <= ptr_next(ptr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= '0;
    else if (wr_bctl) ctl_q <= wdata[CTL_W-1:0];
  end

  assign dbank     = ctl_q[BANK_W-1:0];
  assign ibank     = ctl_q[CTL_W-1:BANK_W];
  assign bctl_byte = DW'(ctl_q);

  p_inc_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_ptr) |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));

  p_wr_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr |=> (ptr_q == $past(wdata[PTR_W-1:0])));
endmodule

// File: rtl/bau_bank_ram.sv
module bau_bank_ram #(
  parameter int unsigned DW     = 8,
  parameter int unsigned OFS_W  = 7,
  parameter int unsigned BANK_W = 2,
  localparam int unsigned NBANK = 1 << BANK_W,
  localparam int unsigned DEPTH = 1 << OFS_W
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic                    re,
  input  logic [BANK_W+OFS_W-1:0] addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata
);
  logic [BANK_W-1:0] bank_idx;
  logic [OFS_W-1:0]  ofs;
  logic [BANK_W-1:0] sel_q;
  logic [DW-1:0]     bank_q [NBANK];

  assign bank_idx = addr[BANK_W+OFS_W-1:OFS_W];
  assign ofs      = addr[OFS_W-1:0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic          hit;
    assign hit = (bank_idx == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (we && hit) mem[ofs] <= wdata;
      if (re && hit) bank_q[b] <= mem[ofs];
    end
  end

  always_ff @(posedge clk) begin
    if (re) sel_q <= bank_idx;
  end

  assign rdata = bank_q[sel_q];
endmodule

// File: rtl/banked_addr_unit.sv
module banked_addr_unit
  import bau_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned OFS_W    = 7,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned WIN_OFS  = 0,
  parameter int unsigned PTR_OFS  = 4,
  parameter int unsigned BCTL_OFS = 3,
  localparam int unsigned AW      = OFS_W + BANK_W,
  localparam int unsigned PTR_W   = OFS_W + 1,
  localparam int unsigned IBANK_W = AW - PTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_we,
  input  logic [OFS_W-1:0] acc_field,
  input  logic [DW-1:0]    acc_wdata,
  input  logic             ptr_inc,
  output logic [AW-1:0]    mem_addr,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);
  logic [PTR_W-1:0]   ptr_q;
  logic [BANK_W-1:0]  dbank;
  logic [IBANK_W-1:0] ibank;
  logic [DW-1:0]      bctl_byte;
  bau_tgt_e           tgt;
  logic               is_win;
  logic               self_ref;
  logic               wr_ptr, wr_bctl, ram_we, ram_re, rd_req;
  logic [DW-1:0]      ram_rdata;
  bau_tgt_e           tgt_q;
  logic [DW-1:0]      reg_snap_q;

  bau_decode #(
    .OFS_W(OFS_W), .BANK_W(BANK_W),
    .WIN_OFS(WIN_OFS), .PTR_OFS(PTR_OFS), .BCTL_OFS(BCTL_OFS)
  ) u_decode (
    .field(acc_field), .dbank(dbank), .ibank(ibank), .ptr(ptr_q),
    .addr(mem_addr), .tgt(tgt), .is_win(is_win), .self_ref(self_ref)
  );

  assign rd_req  = acc_valid && !acc_we;
  assign wr_ptr  = acc_valid && acc_we && (tgt == TGT_PTR);
  assign wr_bctl = acc_valid && acc_we && (tgt == TGT_BCTL);
  assign ram_we  = acc_valid && acc_we && (tgt == TGT_RAM);
  assign ram_re  = rd_req && (tgt == TGT_RAM);

  bau_ctrl_regs #(
    .DW(DW), .PTR_W(PTR_W), .BANK_W(BANK_W), .IBANK_W(IBANK_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .wr_bctl(wr_bctl),
    .inc(ptr_inc), .wdata(acc_wdata), .ptr_q(ptr_q), .dbank(dbank),
    .ibank(ibank), .bctl_byte(bctl_byte)
  );

  bau_bank_ram #(
    .DW(DW), .OFS_W(OFS_W), .BANK_W(BANK_W)
  ) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(mem_addr),
    .wdata(acc_wdata), .rdata(ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      tgt_q      <= TGT_NULL;
      reg_snap_q <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        tgt_q <= tgt;
        case (tgt)
          TGT_PTR:  reg_snap_q <= DW'(ptr_q);
          TGT_BCTL: reg_snap_q <= bctl_byte;
          default:  reg_snap_q <= '0;
        endcase
      end
    end
  end

  always_comb begin
    case (tgt_q)
      TGT_RAM: rd_data = ram_rdata;
      default: rd_data = reg_snap_q;
    endcase
  end

  p_dir_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_field != OFS_W'(WIN_OFS)) |-> (mem_addr[AW-1:OFS_W] == dbank));

  p_win_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_field == OFS_W'(WIN_OFS)) |-> (mem_addr[PTR_W-1:0] == ptr_q));

  p_self_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && self_ref) |=> (rd_valid && rd_data == '0));

  p_self_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_we && self_ref && !ptr_inc) |=> ($stable(ptr_q) && $stable(bctl_byte)));

  p_bctl_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && tgt_q == TGT_BCTL) |-> (rd_data[DW-1:3] == '0));
endmodule

// File: tb/test_banked_addr_unit.sv
module test_banked_addr_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_we = 1'b0;
  logic [6:0] acc_field = '0;
  logic [7:0] acc_wdata = '0;
  logic       ptr_inc = 1'b0;
  logic [8:0] mem_addr;
  logic       rd_valid;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  logic [7:0] m_mem [512];
  logic [7:0] m_ptr = 8'h00;
  logic [2:0] m_ctl = 3'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_addr_unit i_banked_addr_unit (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_field(acc_field), .acc_wdata(acc_wdata), .ptr_inc(ptr_inc),
    .mem_addr(mem_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] model_addr(input logic [6:0] f);
    if (f == 7'h00) return {m_ctl[2], m_ptr};
    return {m_ctl[1:0], f};
  endfunction

  // driver: one access per cycle; reads push their expected value
  task automatic access(input logic [6:0] f, input bit we, input logic [7:0] d,
                        input bit inc, input string tag);
    logic [8:0] a;
    logic [7:0] e;
    @(negedge clk);
    acc_valid = 1'b1; acc_we = we; acc_field = f; acc_wdata = d; ptr_inc = inc;
    a = model_addr(f);
    #1;
    check(mem_addr == a, {tag, " addr"}, mem_addr, a);
    if (!we) begin
      if (f == 7'h00 && a[6:0] == 7'h00) e = 8'h00;
      else if (a[6:0] == 7'h04) e = m_ptr;
      else if (a[6:0] == 7'h03) e = {5'b0, m_ctl};
      else e = m_mem[a];
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    if (we) begin
      if (f == 7'h00 && a[6:0] == 7'h00) begin end
      else if (a[6:0] == 7'h04) m_ptr = d;
      else if (a[6:0] == 7'h03) m_ctl = d[2:0];
      else m_mem[a] = d;
    end
    if (inc && !(we && a[6:0] == 7'h04 && !(f == 7'h00 && a[6:0] == 7'h00)))
      m_ptr = m_ptr + 8'h01;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0; ptr_inc = 1'b0;
  endtask

  // monitor: compares each returned read against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected rd_valid", rd_data, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check(rd_valid == 1'b0, "R1 rd_valid low in reset", rd_valid, 0);
    rst_n = 1'b1;
    access(7'h04, 0, 0, 0, "R1 pointer reset");
    access(7'h03, 0, 0, 0, "R1 bank control reset");
    // seed RAM so later reads are meaningful
    for (int b = 0; b < 4; b++) begin
      access(7'h03, 1, 8'(b), 0, "R6 select bank");
      for (int o = 8'h20; o < 8'h30; o++) access(7'(o), 1, 8'(8'h40 + 16*b + o), 0, "R2 seed");
    end
    access(7'h03, 1, 8'h00, 0, "R2 bank 0");
    access(7'h20, 1, 8'hA5, 0, "R2 write bank 0");
    access(7'h03, 1, 8'h02, 0, "R2 bank 2");
    access(7'h20, 1, 8'h3C, 0, "R2 write bank 2");
    access(7'h20, 0, 0, 0, "R4 read bank 2");
    access(7'h03, 1, 8'h00, 0, "R2 back to bank 0");
    access(7'h20, 0, 0, 0, "R4 read bank 0");
    access(7'h03, 1, 8'hFF, 0, "R9 write all ones");
    access(7'h03, 0, 0, 0, "R9 upper bits zero");
    access(7'h21, 0, 0, 0, "R2 bank 3 read");
    access(7'h04, 1, 8'h20, 0, "R6 pointer via bank 3");
    access(7'h03, 1, 8'h00, 0, "R6 control via bank 3");
    access(7'h04, 0, 0, 0, "R6 pointer via bank 0");
    access(7'h00, 0, 0, 0, "R5 window read ibank 0");
    access(7'h03, 1, 8'h04, 0, "R3 set ibank");
    access(7'h00, 0, 0, 0, "R3 window read ibank 1");
    access(7'h03, 1, 8'h00, 0, "R3 clear ibank");
    for (int i = 0; i < 16; i++) access(7'h00, 1, 8'h00, 1, "R7 clear sweep");
    access(7'h04, 0, 0, 0, "R7 pointer after sweep");
    for (int o = 8'h1F; o < 8'h31; o++) access(7'(o), 0, 0, 0, "R7 swept range");
    access(7'h04, 1, 8'hFF, 1, "R7 write beats increment");
    access(7'h04, 0, 0, 1, "R7 wrap read");
    access(7'h04, 0, 0, 0, "R7 wrapped to 00");
    access(7'h04, 1, 8'h10, 1, "R7 write priority");
    access(7'h04, 0, 0, 0, "R7 priority result");
    access(7'h04, 1, 8'h80, 0, "R8 point at window");
    access(7'h00, 0, 0, 0, "R8 self read zero");
    access(7'h00, 1, 8'h55, 0, "R8 self write");
    access(7'h04, 0, 0, 0, "R8 pointer unchanged");
    access(7'h03, 0, 0, 0, "R8 control unchanged");
    access(7'h04, 1, 8'h84, 0, "R3 window onto pointer");
    access(7'h00, 0, 0, 0, "R3 window reads pointer");
    access(7'h04, 1, 8'hA0, 0, "R5 high pointer");
    access(7'h00, 1, 8'h77, 0, "R5 window write bank 1");
    access(7'h03, 1, 8'h01, 0, "R5 bank 1 direct");
    access(7'h20, 0, 0, 0, "R5 direct sees window write");
    idle();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule